// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from power-on to a usable state. After reset it holds the clock enable low for the power-stabilisation interval. It then raises CKE, waits again, and plays out a fixed list of eleven commands on a small command bus: a two-bit command code plus bank-address and row-address buses. Every wait is counted in controller clocks. The waits are derived at elaboration from nanosecond parameters and the clock period, so one source covers any controller frequency.

The mode-register contents come from four static inputs: the CAS-latency code, the burst-length code, a DLL-off bit and a reduced-drive bit. The memory controller's normal command path is meant to take over the DRAM pins only after `init_done` rises. A separate `auto_ref_en` output keeps the controller's periodic refresh engine off until that moment, so that no stray refresh can fall inside the sequence.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cke`, `init_done`, `auto_ref_en`, `ba` and `addr` are all zero and `cmd` is NOP. The command codes are NOP=2'b00, PRECHARGE ALL=2'b01, LOAD MODE=2'b10 and REFRESH=2'b11.
- R2: `cke` rises exactly ceil(PWR_NS/period) clocks after reset release and then stays high until the next reset.
- R3: No command other than NOP appears while `cke` is low. The first command is PRECHARGE ALL with `addr[10]`=1, issued ceil(CKE_NS/period) clocks after `cke` rises.
- R4: The commands come in this order, given as command and `ba`: PREA; LMR 2'b10 (extended mode register 2); LMR 2'b11 (extended mode register 3); LMR 2'b01 (extended mode register 1); LMR 2'b00 (mode register); PREA; REF; REF; LMR 2'b00; LMR 2'b01; LMR 2'b01. No other command follows.
- R5: `ba[2]` and `addr[15:13]` are always 0. The writes to extended mode registers 2 and 3 carry an all-zero `addr`.
- R6: Each write to extended mode register 1 carries `dll_off` on `addr[0]` and `drv_reduced` on `addr[1]`, with every other bit zero except `addr[9:7]`. That field is 3'b000 on the first write, 3'b111 (OCD default) on the second and 3'b000 (OCD exit) on the third.
- R7: Each mode-register write carries `burst_code` on `addr[2:0]` and `cas_lat` on `addr[6:4]`, with every other bit zero except `addr[8]`. That bit is 1 (DLL reset) on the first write and 0 on the second.
- R8: Every command lasts one clock and is followed by at least one NOP. The spacing to the next command is max(2, MRD_CLKS) after LOAD MODE, max(2, ceil(RP_NS/period)) after PRECHARGE ALL and max(2, ceil(RFC_NS/period)) after REFRESH.
- R9: The second PRECHARGE ALL follows the DLL-reset mode-register write by max(2, MRD_CLKS, DLLRST_CLKS) clocks.
- R10: `init_done` rises max(2, MRD_CLKS) clocks after the final extended-mode-register-1 write appears, and stays high until reset.
- R11: `auto_ref_en` stays low until `init_done` rises, rises on the same cycle, and no command is driven while it is high.
- R12: A reset in the middle of the sequence returns every output to its R1 value, and a fresh, complete sequence follows the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cas_lat | input | 3 | CAS-latency code for the mode register |
| burst_code | input | 3 | Burst-length code for the mode register |
| dll_off | input | 1 | Extended mode register 1 DLL-disable bit |
| drv_reduced | input | 1 | Extended mode register 1 reduced-drive bit |
| cke | output | 1 | DRAM clock enable |
| cmd | output | 2 | Command code (NOP, PREA, LMR, REF) |
| ba | output | 3 | Bank address |
| addr | output | 16 | Row address / mode-register word |
| init_done | output | 1 | Initialization finished |
| auto_ref_en | output | 1 | Permission for the periodic refresh engine |

## Verification
The release of `auto_ref_en` and the last extended-mode-register-1 write can come within a single gap of each other. With the minimum two-clock gap they are one NOP apart. The bench runs the shortest legal gap so that an off-by-one in the final wait would put the release on the same cycle as the last command or ahead of it. At every sampled cycle it checks that a command and a high `auto_ref_en` never coincide. It also checks that the release arrives exactly one gap after the final write.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_PREA = 2'b01,
    CMD_LMR  = 2'b10,
    CMD_REF  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    GAP_RP,
    GAP_MRD,
    GAP_RFC,
    GAP_DLL
  } gap_e;

  localparam logic [2:0] BA_MR   = 3'b000;
  localparam logic [2:0] BA_EMR1 = 3'b001;
  localparam logic [2:0] BA_EMR2 = 3'b010;
  localparam logic [2:0] BA_EMR3 = 3'b011;

  localparam logic [3:0] N_STEPS = 4'd11;

  typedef struct packed {
    cmd_e        cmd;
    logic [2:0]  ba;
    logic [15:0] addr;
    gap_e        gap;
  } step_t;

  // nanoseconds to whole clocks, rounded up
  function automatic int unsigned ns_to_clk(input int unsigned ns,
                                            input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  // every command must be followed by at least one NOP
  function automatic int unsigned min_gap(input int unsigned v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [15:0] mr_word(input logic [2:0] cl,
                                          input logic [2:0] bl,
                                          input logic       dll_rst);
    logic [15:0] w;
    w      = '0;
    w[2:0] = bl;
    w[6:4] = cl;
    w[8]   = dll_rst;
    return w;
  endfunction

  function automatic logic [15:0] emr1_word(input logic       dll_off,
                                            input logic       drv,
                                            input logic [2:0] ocd);
    logic [15:0] w;
    w      = '0;
    w[0]   = dll_off;
    w[1]   = drv;
    w[9:7] = ocd;
    return w;
  endfunction

  function automatic logic [15:0] prea_word();
    logic [15:0] w;
    w     = '0;
    w[10] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int unsigned W       = 16,
  parameter int unsigned RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= W'(RST_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/ddr2_init_steps.sv
module ddr2_init_steps
  import ddr2_init_pkg::*;
(
  input  logic [3:0] idx,
  input  logic [2:0] cas_lat,
  input  logic [2:0] burst_code,
  input  logic       dll_off,
  input  logic       drv_reduced,
  output step_t      step
);

  always_comb begin
    step.cmd  = CMD_NOP;
    step.ba   = BA_MR;
    step.addr = '0;
    step.gap  = GAP_MRD;
    case (idx)
      4'd0: begin
        step.cmd  = CMD_PREA;
        step.addr = prea_word();
        step.gap  = GAP_RP;
      end
      4'd1: begin
        step.cmd = CMD_LMR;
        step.ba  = BA_EMR2;
      end
      4'd2: begin
        step.cmd = CMD_LMR;
        step.ba  = BA_EMR3;
      end
      4'd3: begin
        step.cmd  = CMD_LMR;
        step.ba   = BA_EMR1;
        step.addr = emr1_word(dll_off, drv_reduced, 3'b000);
      end
      4'd4: begin
        step.cmd  = CMD_LMR;
        step.ba   = BA_MR;
        step.addr = mr_word(cas_lat, burst_code, 1'b1);
        step.gap  = GAP_DLL;
      end
      4'd5: begin
        step.cmd  = CMD_PREA;
        step.addr = prea_word();
        step.gap  = GAP_RP;
      end
      4'd6, 4'd7: begin
        step.cmd = CMD_REF;
        step.gap = GAP_RFC;
      end
      4'd8: begin
        step.cmd  = CMD_LMR;
        step.ba   = BA_MR;
        step.addr = mr_word(cas_lat, burst_code, 1'b0);
      end
      4'd9: begin
        step.cmd  = CMD_LMR;
        step.ba   = BA_EMR1;
        step.addr = emr1_word(dll_off, drv_reduced, 3'b111);
      end
      4'd10: begin
        step.cmd  = CMD_LMR;
        step.ba   = BA_EMR1;
        step.addr = emr1_word(dll_off, drv_reduced, 3'b000);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr2_init_ctrl.sv
module ddr2_init_ctrl
  import ddr2_init_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned CKE_CK = 100,
  parameter int unsigned G_RP   = 2,
  parameter int unsigned G_MRD  = 2,
  parameter int unsigned G_RFC  = 2,
  parameter int unsigned G_DLL  = 200
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         expired,
  input  step_t        cur,
  output logic [3:0]   idx,
  output logic         load,
  output logic [W-1:0] load_val,
  output logic         issue_evt,
  output logic         seq_end,
  output logic         cke,
  output cmd_e         cmd,
  output logic [2:0]   ba,
  output logic [15:0]  addr,
  output logic         done
);

  typedef enum logic [1:0] {ST_PWR, ST_RUN, ST_DONE} st_e;
  st_e st;

  logic [W-1:0] gap_val;

  always_comb begin
    case (cur.gap)
      GAP_RP:  gap_val = W'(G_RP - 1);
      GAP_RFC: gap_val = W'(G_RFC - 1);
      GAP_DLL: gap_val = W'(G_DLL - 1);
      default: gap_val = W'(G_MRD - 1);
    endcase
  end

  assign issue_evt = (st == ST_RUN) && expired && (idx != N_STEPS);
  assign seq_end   = (st == ST_RUN) && expired && (idx == N_STEPS);
  assign load      = ((st == ST_PWR) && expired) || issue_evt;
  assign load_val  = (st == ST_PWR) ? W'(CKE_CK - 1) : gap_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_PWR;
      idx  <= '0;
      cke  <= 1'b0;
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
      done <= 1'b0;
    end else begin
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
      case (st)
        ST_PWR: begin
          if (expired) begin
            cke <= 1'b1;
            st  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (issue_evt) begin
            cmd  <= cur.cmd;
            ba   <= cur.ba;
            addr <= cur.addr;
            idx  <= idx + 1'b1;
          end else if (seq_end) begin
            done <= 1'b1;
            st   <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned CLK_PS      = 4000,
  parameter int unsigned PWR_NS      = 200000,
  parameter int unsigned CKE_NS      = 400,
  parameter int unsigned RP_NS       = 15,
  parameter int unsigned RFC_NS      = 128,
  parameter int unsigned MRD_CLKS    = 2,
  parameter int unsigned DLLRST_CLKS = 200
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  cas_lat,
  input  logic [2:0]  burst_code,
  input  logic        dll_off,
  input  logic        drv_reduced,
  output logic        cke,
  output logic [1:0]  cmd,
  output logic [2:0]  ba,
  output logic [15:0] addr,
  output logic        init_done,
  output logic        auto_ref_en
);

  localparam int unsigned PWR_CK = max2(ns_to_clk(PWR_NS, CLK_PS), 1);
  localparam int unsigned CKE_CK = max2(ns_to_clk(CKE_NS, CLK_PS), 1);
  localparam int unsigned G_RP   = min_gap(ns_to_clk(RP_NS, CLK_PS));
  localparam int unsigned G_RFC  = min_gap(ns_to_clk(RFC_NS, CLK_PS));
  localparam int unsigned G_MRD  = min_gap(MRD_CLKS);
  localparam int unsigned G_DLL  = min_gap(max2(DLLRST_CLKS, MRD_CLKS));
  localparam int unsigned MAX_CK = max2(max2(PWR_CK, CKE_CK),
                                        max2(max2(G_RP, G_RFC), max2(G_MRD, G_DLL)));
  localparam int unsigned W      = $clog2(MAX_CK + 1);

  logic [3:0]   idx;
  step_t        cur;
  logic         load;
  logic [W-1:0] load_val;
  logic         expired;
  logic         issue_evt;
  logic         seq_end;
  cmd_e         cmd_q;

  ddr2_init_timer #(
    .W       (W),
    .RST_VAL (PWR_CK - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  ddr2_init_steps u_steps (
    .idx         (idx),
    .cas_lat     (cas_lat),
    .burst_code  (burst_code),
    .dll_off     (dll_off),
    .drv_reduced (drv_reduced),
    .step        (cur)
  );

  ddr2_init_ctrl #(
    .W      (W),
    .CKE_CK (CKE_CK),
    .G_RP   (G_RP),
    .G_MRD  (G_MRD),
    .G_RFC  (G_RFC),
    .G_DLL  (G_DLL)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .expired   (expired),
    .cur       (cur),
    .idx       (idx),
    .load      (load),
    .load_val  (load_val),
    .issue_evt (issue_evt),
    .seq_end   (seq_end),
    .cke       (cke),
    .cmd       (cmd_q),
    .ba        (ba),
    .addr      (addr),
    .done      (init_done)
  );

  assign cmd         = cmd_q;
  assign auto_ref_en = init_done;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk
  import ddr2_init_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        cke,
  input logic [1:0]  cmd,
  input logic [2:0]  ba,
  input logic [15:0] addr,
  input logic        init_done,
  input logic        auto_ref_en,
  input logic        issue_evt,
  input logic        seq_end
);

  logic [7:0] since;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (cmd != CMD_NOP) begin
      since <= 8'd1;
      seen  <= 1'b1;
    end else if (since != 8'hFF) begin
      since <= since + 1'b1;
    end
  end

  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  // R3
  cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |-> cke);

  // R3
  prea_a10_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PREA) |-> addr[10]);

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ba[2] == 1'b0) && (addr[15:13] == 3'b000));

  // R8
  nop_after_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

  // R8
  min_space_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd != CMD_NOP) && seen) |-> (since >= 8'd2));

  // R8
  issue_reach_chk: assert property (@(posedge clk) disable iff (rst)
    issue_evt |=> (cmd != CMD_NOP));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R10
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    seq_end |=> $rose(init_done));

  // R11
  ref_gate_chk: assert property (@(posedge clk) disable iff (rst)
    auto_ref_en |-> (init_done && (cmd == CMD_NOP)));

endmodule

bind ddr2_pwrup_seq ddr2_init_seq_chk u_seq_chk (
  .clk         (clk),
  .rst         (rst),
  .cke         (cke),
  .cmd         (cmd),
  .ba          (ba),
  .addr        (addr),
  .init_done   (init_done),
  .auto_ref_en (auto_ref_en),
  .issue_evt   (issue_evt),
  .seq_end     (seq_end)
);

// File: tb/test_ddr2_pwrup_seq.sv
module test_ddr2_pwrup_seq;

  // 250 MHz: 4000 ps period, power wait shortened to 2000 ns for the bench
  localparam int T_PWR = 500;   // 2000 ns / 4 ns
  localparam int T_CKE = 100;   // 400 ns / 4 ns
  localparam int T_RP  = 4;     // 15 ns -> 3.75 clocks, rounded up
  localparam int T_RFC = 32;    // 128 ns / 4 ns
  localparam int T_MRD = 2;
  localparam int T_DLL = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cas_lat = 3'd2;
  logic [2:0]  burst_code = 3'd2;
  logic        dll_off = 1'b0;
  logic        drv_reduced = 1'b0;
  logic        cke;
  logic [1:0]  cmd;
  logic [2:0]  ba;
  logic [15:0] addr;
  logic        init_done;
  logic        auto_ref_en;

  always #2 clk = ~clk;

  ddr2_pwrup_seq #(
    .CLK_PS (4000),
    .PWR_NS (2000)
  ) i_ddr2_pwrup_seq (
    .clk         (clk),
    .rst         (rst),
    .cas_lat     (cas_lat),
    .burst_code  (burst_code),
    .dll_off     (dll_off),
    .drv_reduced (drv_reduced),
    .cke         (cke),
    .cmd         (cmd),
    .ba          (ba),
    .addr        (addr),
    .init_done   (init_done),
    .auto_ref_en (auto_ref_en)
  );

  int n_chk  = 0;
  int n_fail = 0;

  logic [1:0]  r_cmd  [16];
  logic [2:0]  r_ba   [16];
  logic [15:0] r_addr [16];
  int          r_cyc  [16];
  int          n_cmd;
  int          cke_cyc, done_cyc, ar_cyc;
  bit          bad_overlap, cke_fell, done_fell, cmd_no_cke;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [1:0] exp_cmd(input int k);
    case (k)
      0, 5:    return 2'b01;
      6, 7:    return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [2:0] exp_ba(input int k);
    case (k)
      1:       return 3'd2;
      2:       return 3'd3;
      3, 9, 10: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic int exp_gap(input int k);
    case (k)
      0, 5:    return T_RP;
      4:       return T_DLL;
      6, 7:    return T_RFC;
      default: return T_MRD;
    endcase
  endfunction

  function automatic logic [15:0] exp_addr(input int k);
    logic [15:0] e1;
    logic [15:0] m;
    e1 = {15'd0, dll_off} + ({15'd0, drv_reduced} << 1);
    m  = {13'd0, burst_code} + ({13'd0, cas_lat} << 4);
    case (k)
      0, 5:  return 16'h0400;
      3, 10: return e1;
      9:     return e1 | 16'h0380;
      4:     return m | 16'h0100;
      8:     return m;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic apply_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic capture(input int limit);
    int cyc = 0;
    n_cmd = 0; cke_cyc = -1; done_cyc = -1; ar_cyc = -1;
    bad_overlap = 0; cke_fell = 0; done_fell = 0; cmd_no_cke = 0;
    while (cyc < limit) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cke && cke_cyc < 0) cke_cyc = cyc;
      if (!cke && cke_cyc >= 0) cke_fell = 1;
      if (cmd != 2'b00) begin
        if (!cke) cmd_no_cke = 1;
        if (n_cmd < 16) begin
          r_cmd[n_cmd] = cmd; r_ba[n_cmd] = ba;
          r_addr[n_cmd] = addr; r_cyc[n_cmd] = cyc;
        end
        n_cmd++;
      end
      if (auto_ref_en && ar_cyc < 0) ar_cyc = cyc;
      if (auto_ref_en && cmd != 2'b00) bad_overlap = 1;
      if (init_done && done_cyc < 0) done_cyc = cyc;
      if (!init_done && done_cyc >= 0) done_fell = 1;
      if (done_cyc >= 0 && cyc > done_cyc + 20) break;
    end
  endtask

  task automatic run_seq(input logic d_off, input logic drv,
                         input logic [2:0] cl, input logic [2:0] bl);
    dll_off = d_off; drv_reduced = drv; cas_lat = cl; burst_code = bl;
    apply_reset();
    capture(3000);
    check(cke_cyc == T_PWR, "R2 cke rise cycle", cke_cyc, T_PWR);
    check(!cke_fell, "R2 cke held high", cke_fell, 0);
    check(!cmd_no_cke, "R3 command with cke low", cmd_no_cke, 0);
    check(n_cmd == 11, "R4 command count", n_cmd, 11);
    if (n_cmd >= 1)
      check(r_cyc[0] - cke_cyc == T_CKE, "R3 first command delay", r_cyc[0] - cke_cyc, T_CKE);
    for (int k = 0; k < 11 && k < n_cmd; k++) begin
      check(r_cmd[k] == exp_cmd(k), "R4 command code", r_cmd[k], exp_cmd(k));
      check(r_ba[k] == exp_ba(k), "R4 bank select", r_ba[k], exp_ba(k));
      if (k == 1 || k == 2)
        check(r_addr[k] == exp_addr(k), "R5 emr2/emr3 word", r_addr[k], exp_addr(k));
      else if (k == 3 || k == 9 || k == 10)
        check(r_addr[k] == exp_addr(k), "R6 emr1 word", r_addr[k], exp_addr(k));
      else if (k == 4 || k == 8)
        check(r_addr[k] == exp_addr(k), "R7 mr word", r_addr[k], exp_addr(k));
      else
        check(r_addr[k] == exp_addr(k), "R3 precharge/refresh word", r_addr[k], exp_addr(k));
      if (k < 10 && k + 1 < n_cmd) begin
        if (k == 4)
          check(r_cyc[k+1] - r_cyc[k] == T_DLL, "R9 dll reset wait",
                r_cyc[k+1] - r_cyc[k], T_DLL);
        else
          check(r_cyc[k+1] - r_cyc[k] == exp_gap(k), "R8 command spacing",
                r_cyc[k+1] - r_cyc[k], exp_gap(k));
      end
    end
    if (n_cmd >= 11)
      check(done_cyc - r_cyc[10] == T_MRD, "R10 done timing", done_cyc - r_cyc[10], T_MRD);
    check(!done_fell, "R10 done held", done_fell, 0);
    check(ar_cyc == done_cyc && ar_cyc > 0, "R11 refresh release cycle", ar_cyc, done_cyc);
    check(!bad_overlap, "R11 command during refresh release", bad_overlap, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check({cke, cmd, ba, addr, init_done, auto_ref_en} == '0, "R1 reset outputs",
          {cke, cmd, ba, addr, init_done, auto_ref_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(cmd == 2'b00 && !cke && !init_done, "R1 first cycle after reset",
          {cke, cmd, init_done}, 0);
  endtask

  task automatic t_midreset();
    int seen = 0;
    apply_reset();
    while (seen < 5) begin
      @(negedge clk);
      if (cmd != 2'b00) seen++;
    end
    rst = 1'b1;
    @(negedge clk);
    check({cke, cmd, ba, addr, init_done, auto_ref_en} == '0, "R12 outputs after mid reset",
          {cke, cmd, ba, addr, init_done, auto_ref_en}, 0);
    run_seq(1'b0, 1'b1, 3'd2, 3'd2);
    check(n_cmd == 11, "R12 full sequence after restart", n_cmd, 11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    run_seq(1'b0, 1'b0, 3'd2, 3'd2);
    run_seq(1'b1, 1'b1, 3'b101, 3'b011);
    t_midreset();
    summary();
    $finish;
  end

endmodule